// File: doc/BRIEF.md
# Single-Channel Event Timestamp Capture

This block takes a snapshot of a free-running 32-bit time value when a chosen event occurs. The event is either an edge on an asynchronous external request pin or a one-cycle-per-event internal trigger. Software reaches the block through a small word-wide register port. The status word carries a valid flag, a sticky miss flag, the source select and an event count. The snapshot is read as two 16-bit halves. A configuration word sets edge polarity, overwrite behaviour and counting.

Before arming, software writes the configuration and then the status word. Any write of the status word clears the event count. After a capture, software reads the two halves and writes the status word with the valid bit at zero. This re-arms the block for the next snapshot. An event that arrives before software has re-armed the block raises the miss flag. Whether that late event replaces the held snapshot depends on the overwrite setting.

Top module: `evcap_top`

## Requirements
- R1: After reset the status word (address 0), both timestamp halves (addresses 1 and 2) and the configuration word (address 3) all read as zero.
- R2: With configuration bit 0 clear, a rising edge on `ext_req` is an event. The pin passes through two synchronizing flops, so the captured value is the `time_now` sampled two clock edges after the first edge that sees the new pin level. Falling edges are ignored in this mode.
- R3: With configuration bit 0 set, a falling edge on `ext_req` is the event and rising edges are ignored. The capture latency is the same as in R2.
- R4: Status bit 2 selects the source. At 1, each cycle with `int_trig` high is an event and `ext_req` is ignored. At 0, `ext_req` edges are events and `int_trig` is ignored. An internal event captures the `time_now` of its own cycle.
- R5: An event while status bit 0 (valid) is clear latches `time_now` and sets valid. Address 1 reads bits 15:0 of the snapshot and address 2 reads bits 31:16.
- R6: An event while valid is set and configuration bit 1 (overwrite) is clear leaves the snapshot unchanged and sets status bit 1 (error).
- R7: An event while valid is set and overwrite is set replaces the snapshot with the new time and also sets the error flag.
- R8: Writing the status word with bit 0 at 0 clears valid. Writing bit 0 at 1 keeps the current valid value and never sets it.
- R9: The error flag stays set until the status word is written with bit 1 at 0. Writing bit 1 at 1 keeps it.
- R10: With configuration bit 2 (count enable) set, status bits 15:8 count every detected event and saturate at 255.
- R11: Any write of the status word sets the event count to zero.
- R12: With count enable clear, the count does not change on events, and capture still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 32 | Free-running time value to be captured |
| ext_req | input | 1 | Asynchronous external event request pin |
| int_trig | input | 1 | Synchronous internal trigger, one event per high cycle |
| reg_addr | input | 2 | Register select: 0 status, 1 snapshot low, 2 snapshot high, 3 configuration |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |

## Verification
The bench first drives rising and then falling pin edges under each polarity setting. This shows whether the right edge is detected and whether the two-flop latency appears in the captured time. A second event is then raised with overwrite off and with overwrite on. Comparing the held snapshot against both event times shows which event won, and shows that the miss flag rose in both cases. Internal pulses are driven under each source setting to confirm that only the selected source counts. A long unbroken run of internal events checks saturation of the counter. Status writes with different bit patterns tell clearing apart from keeping, for both valid and error.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_TS_LO  = 2'd1,
    SEL_TS_HI  = 2'd2,
    SEL_CONFIG = 2'd3
  } reg_sel_e;

  // status word bit positions
  localparam int ST_VALID = 0;
  localparam int ST_ERROR = 1;
  localparam int ST_SRC   = 2;

  // configuration word bit positions
  localparam int CF_FALL   = 0;
  localparam int CF_OVWR   = 1;
  localparam int CF_CNT_EN = 2;
  localparam int CF_BITS   = 3;

  typedef struct packed {
    logic cnt_en;
    logic ovwr;
    logic fall;
  } cap_cfg_t;

  // a write-one-keeps / write-zero-clears flag update
  function automatic logic keep_or_clear(input logic cur, input logic wbit);
    return cur & wbit;
  endfunction

endpackage

// File: rtl/evcap_edge.sv
module evcap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic fall_sel,
  output logic edge_evt
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise_w;
  logic              fall_w;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign rise_w   = sync_q[LAST] & ~prev_q;
  assign fall_w   = ~sync_q[LAST] & prev_q;
  assign edge_evt = fall_sel ? fall_w : rise_w;

  // R2/R3: with a steady polarity, one synchronized transition yields one event
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> (!edge_evt || (fall_sel != $past(fall_sel))));

  // R3: a falling-mode event is a drop of the synchronized level
  a_r3_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && fall_sel) |=> !prev_q);

endmodule

// File: rtl/evcap_core.sv
module evcap_core #(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic              evt,
  input  logic              ovwr,
  input  logic              cnt_en,
  input  logic              st_wr,
  input  logic              st_wvalid,
  input  logic              st_werr,
  output logic              valid,
  output logic              err,
  output logic [TIME_W-1:0] stamp,
  output logic [CNT_W-1:0]  count
);
  import evcap_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic              take_w;
  logic              miss_w;
  logic              valid_n, err_n;
  logic [TIME_W-1:0] stamp_n;
  logic [CNT_W-1:0]  count_n;

  assign take_w = evt & (~valid | ovwr);
  assign miss_w = evt & valid;

  always_comb begin
    valid_n = st_wr ? keep_or_clear(valid, st_wvalid) : valid;
    err_n   = st_wr ? keep_or_clear(err, st_werr) : err;
    if (evt)    valid_n = 1'b1;
    if (miss_w) err_n   = 1'b1;
    stamp_n = take_w ? time_now : stamp;
    if (st_wr)              count_n = '0;
    else if (evt && cnt_en) count_n = sat_inc(count);
    else                    count_n = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      err   <= 1'b0;
      stamp <= '0;
      count <= '0;
    end else begin
      valid <= valid_n;
      err   <= err_n;
      stamp <= stamp_n;
      count <= count_n;
    end
  end

  a_r5_event_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> valid);
  a_r5_first_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !valid) |=> (stamp == $past(time_now)));
  a_r6_keep_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && valid && !ovwr) |=> $stable(stamp));
  a_r6_miss_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && valid) |=> err);
  a_r7_overwrite_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ovwr) |=> (stamp == $past(time_now)));
  a_r8_no_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !st_wvalid && !evt) |=> !valid);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !st_wr) |=> err);
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == CNT_MAX) && !st_wr) |=> (count == CNT_MAX));
  a_r11_write_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> (count == '0));
  a_r12_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !st_wr) |=> $stable(count));

endmodule

// File: rtl/evcap_regs.sv
module evcap_regs #(
  parameter int DATA_W = 16,
  parameter int TIME_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              valid,
  input  logic              err,
  input  logic [TIME_W-1:0] stamp,
  input  logic [CNT_W-1:0]  count,
  output evcap_pkg::cap_cfg_t cfg,
  output logic              src_int,
  output logic              st_wr,
  output logic              st_wvalid,
  output logic              st_werr,
  output logic [DATA_W-1:0] reg_rdata
);
  import evcap_pkg::*;

  localparam int HALF_W  = TIME_W / 2;
  localparam int CNT_LSB = DATA_W - CNT_W;

  reg_sel_e            sel;
  logic                cfg_wr;
  logic [DATA_W-1:0]   status_w;
  logic [DATA_W-1:0]   config_w;
  logic                unused_wbits;

  assign sel       = reg_sel_e'(reg_addr);
  assign st_wr     = reg_wr && (sel == SEL_STATUS);
  assign cfg_wr    = reg_wr && (sel == SEL_CONFIG);
  assign st_wvalid = reg_wdata[ST_VALID];
  assign st_werr   = reg_wdata[ST_ERROR];
  assign unused_wbits = ^reg_wdata[DATA_W-1:CF_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      src_int <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg.fall   <= reg_wdata[CF_FALL];
        cfg.ovwr   <= reg_wdata[CF_OVWR];
        cfg.cnt_en <= reg_wdata[CF_CNT_EN];
      end
      if (st_wr) src_int <= reg_wdata[ST_SRC];
    end
  end

  always_comb begin
    status_w = '0;
    status_w[ST_VALID] = valid;
    status_w[ST_ERROR] = err;
    status_w[ST_SRC]   = src_int;
    status_w[DATA_W-1:CNT_LSB] = count;
    config_w = '0;
    config_w[CF_FALL]   = cfg.fall;
    config_w[CF_OVWR]   = cfg.ovwr;
    config_w[CF_CNT_EN] = cfg.cnt_en;
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS: reg_rdata = status_w;
      SEL_TS_LO:  reg_rdata = DATA_W'(stamp[HALF_W-1:0]);
      SEL_TS_HI:  reg_rdata = DATA_W'(stamp[TIME_W-1:HALF_W]);
      default:    reg_rdata = config_w;
    endcase
  end

  // R4: the source bit only moves on a status write
  a_r4_src_held: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> $stable(src_int));

endmodule

// File: rtl/evcap_top.sv
module evcap_top #(
  parameter int TIME_W      = 32,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic              ext_req,
  input  logic              int_trig,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  import evcap_pkg::*;

  cap_cfg_t          cfg;
  logic              src_int;
  logic              ext_evt;
  logic              sel_evt;
  logic              st_wr, st_wvalid, st_werr;
  logic              valid, err;
  logic [TIME_W-1:0] stamp;
  logic [CNT_W-1:0]  count;

  evcap_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ext_req),
    .fall_sel  (cfg.fall),
    .edge_evt  (ext_evt)
  );

  assign sel_evt = src_int ? int_trig : ext_evt;

  evcap_core #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_now  (time_now),
    .evt       (sel_evt),
    .ovwr      (cfg.ovwr),
    .cnt_en    (cfg.cnt_en),
    .st_wr     (st_wr),
    .st_wvalid (st_wvalid),
    .st_werr   (st_werr),
    .valid     (valid),
    .err       (err),
    .stamp     (stamp),
    .count     (count)
  );

  evcap_regs #(.DATA_W(DATA_W), .TIME_W(TIME_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .valid     (valid),
    .err       (err),
    .stamp     (stamp),
    .count     (count),
    .cfg       (cfg),
    .src_int   (src_int),
    .st_wr     (st_wr),
    .st_wvalid (st_wvalid),
    .st_werr   (st_werr),
    .reg_rdata (reg_rdata)
  );

  // R4: a selected event never comes from the deselected source
  a_r4_int_only: assert property (@(posedge clk) disable iff (!rst_n)
    (src_int && !int_trig) |-> !sel_evt);
  a_r4_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_int && !ext_evt) |-> !sel_evt);

endmodule

// File: tb/tb_evcap_top.sv
module tb_evcap_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tnow = 32'h1234_FFF0;
  logic        ext_req = 1'b0;
  logic        int_trig = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  evcap_top dut (
    .clk(clk), .rst_n(rst_n), .time_now(tnow), .ext_req(ext_req),
    .int_trig(int_trig), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tnow <= tnow + 32'd1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_stamp(output logic [31:0] s);
    logic [15:0] lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    s = {hi, lo};
  endtask

  task automatic pin(input logic v, output logic [31:0] t);
    @(negedge clk);
    ext_req = v;
    t = tnow;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(output logic [31:0] t);
    @(negedge clk);
    int_trig = 1'b1;
    t = tnow;
    @(negedge clk);
    int_trig = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk($sformatf("R1 reset word %0d", a), {16'd0, d}, 32'd0);
    end
  endtask

  task automatic t_rising;
    logic [31:0] t, s, t2;
    logic [15:0] d;
    wr(2'd3, 16'h0004);
    wr(2'd0, 16'h0000);
    pin(1'b1, t);
    rd_stamp(s);
    chk("R2 R5 rising capture", s, t + 32'd2);
    rd(2'd0, d);
    chk("R5 R10 status after capture", {16'd0, d}, 32'h0101);
    pin(1'b0, t2);
    rd(2'd0, d);
    chk("R2 falling edge ignored", {16'd0, d}, 32'h0101);
    pin(1'b1, t2);
    rd_stamp(s);
    chk("R6 snapshot kept on miss", s, t + 32'd2);
    rd(2'd0, d);
    chk("R6 error flagged", {16'd0, d}, 32'h0203);
  endtask

  task automatic t_clear;
    logic [15:0] d;
    wr(2'd0, 16'h0003);
    rd(2'd0, d);
    chk("R11 R8 keep flags, zero count", {16'd0, d}, 32'h0003);
    wr(2'd0, 16'h0002);
    rd(2'd0, d);
    chk("R8 R9 valid cleared, error kept", {16'd0, d}, 32'h0002);
    wr(2'd0, 16'h0001);
    rd(2'd0, d);
    chk("R8 R9 valid not set, error cleared", {16'd0, d}, 32'h0000);
  endtask

  task automatic t_overwrite;
    logic [31:0] ta, tb, s;
    logic [15:0] d;
    wr(2'd3, 16'h0006);
    pin(1'b0, ta);
    pin(1'b1, ta);
    pin(1'b0, tb);
    pin(1'b1, tb);
    rd_stamp(s);
    chk("R7 overwrite takes later event", s, tb + 32'd2);
    rd(2'd0, d);
    chk("R7 error flagged with overwrite", {16'd0, d}, 32'h0203);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_falling;
    logic [31:0] tf, tx, s;
    logic [15:0] d;
    wr(2'd3, 16'h0005);
    rd(2'd3, d);
    chk("R3 config readback", {16'd0, d}, 32'h0005);
    pin(1'b0, tf);
    rd_stamp(s);
    chk("R3 falling capture", s, tf + 32'd2);
    pin(1'b1, tx);
    rd(2'd0, d);
    chk("R3 rising ignored", {16'd0, d}, 32'h0101);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_source;
    logic [31:0] ti, tx, s;
    logic [15:0] d;
    wr(2'd0, 16'h0004);
    pulse(ti);
    rd_stamp(s);
    chk("R4 internal capture time", s, ti);
    pin(1'b0, tx);
    rd(2'd0, d);
    chk("R4 pin ignored when internal", {16'd0, d}, 32'h0105);
    wr(2'd0, 16'h0000);
    pulse(tx);
    rd(2'd0, d);
    chk("R4 trigger ignored when external", {16'd0, d}, 32'h0000);
    rd_stamp(s);
    chk("R4 snapshot unchanged", s, ti);
  endtask

  task automatic t_saturate;
    logic [15:0] d;
    wr(2'd3, 16'h0004);
    wr(2'd0, 16'h0004);
    @(negedge clk);
    int_trig = 1'b1;
    repeat (300) @(negedge clk);
    int_trig = 1'b0;
    rd(2'd0, d);
    chk("R10 count saturates", {16'd0, d}, 32'hFF07);
    wr(2'd0, 16'h0004);
    rd(2'd0, d);
    chk("R11 write zeroes count", {16'd0, d}, 32'h0004);
  endtask

  task automatic t_count_off;
    logic [31:0] tp, s;
    logic [15:0] d;
    wr(2'd3, 16'h0000);
    pulse(tp);
    rd(2'd0, d);
    chk("R12 no count when disabled", {16'd0, d}, 32'h0005);
    rd_stamp(s);
    chk("R12 capture still works", s, tp);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rising();
    t_clear();
    t_overwrite();
    t_falling();
    t_source();
    t_saturate();
    t_count_off();
    finish_run();
  end

endmodule